// File: doc/BRIEF.md
# Secondary Processor Boot Sequencer

This block brings the secondary processors of a multi-core cluster out of reset one at a time. A single start pulse walks the bitmap of enabled processors from the lowest index upward. For each enabled target it writes a command sequence into an interrupt command port: an INIT assert, an INIT deassert, a fixed settling delay, and then two startup commands that each carry the boot-code page number, with a shorter delay after each. It then waits for the target to raise its own bit in a shared completion bitmap before it moves on.

The command transport is modelled as a write strobe and a busy flag. The sequencer writes only when busy is low, so a command is never stacked onto one still in flight. All delays are counted in microseconds on a free-running tick input, with a parameter giving ticks per microsecond. A target that does not report completion within a programmable number of microseconds is marked as failed, and the walk continues with the next target. A done flag reports the end of the walk and holds until the next start.

Top module: `ap_boot_seq`

## Requirements
- R1: After reset no command is written, `done_o` is low and `failed_o` is all zero.
- R2: Targets are visited in ascending index order. A target whose bit in `enabled_i` is 0 receives no command. The destination field of every command equals the target index.
- R3: Each target receives exactly four commands in this order, with `cmd_type_o` encoded as follows: INIT assert (0) with vector 0, INIT deassert (1) with vector 0, then startup (2), then startup (2) again.
- R4: Both startup commands carry `page_i` in `cmd_vec_o`.
- R5: A command is written only in a cycle that follows a cycle in which `busy_i` was sampled low. `cmd_valid_o` is a one-cycle pulse. When the INIT assert has been written, the INIT deassert follows in the first cycle that sees busy idle.
- R6: The first startup command is written `INIT_US*TICKS_PER_US` ticks plus two cycles after the INIT deassert, provided busy is idle.
- R7: The second startup command is written `SIPI_US*TICKS_PER_US` ticks plus two cycles after the first. The completion bit is not examined until the same delay has also elapsed after the second.
- R8: The INIT assert for the next target is not written before bit n of `online_i` is set for the current target n, unless R9 applies.
- R9: If `online_i[n]` is still low `timeout_us_i` microseconds after the wait that follows the second startup command, `failed_o[n]` is set. The next target's INIT assert then follows `(SIPI_US+timeout_us_i)*TICKS_PER_US+4` cycles after that startup command.
- R10: `done_o` rises after the last enabled target has completed or failed. It stays high until the next `start_i`. A `start_i` pulse received while the walk is in progress is ignored.
- R11: When `enabled_i` is all zero, a start produces no command and raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a boot walk when idle or done |
| enabled_i | input | N_CPU | Bit n set: processor n is to be booted |
| page_i | input | 8 | Boot-code page number for startup commands |
| busy_i | input | 1 | Command port still delivering the previous write |
| online_i | input | N_CPU | Bit n set by processor n once it is running |
| tick_i | input | 1 | Time-base tick, TICKS_PER_US per microsecond |
| timeout_us_i | input | DLY_W | Completion timeout in microseconds |
| cmd_valid_o | output | 1 | One-cycle command write strobe |
| cmd_type_o | output | 2 | 0 INIT assert, 1 INIT deassert, 2 startup |
| cmd_dest_o | output | clog2(N_CPU) | Destination processor index |
| cmd_vec_o | output | 8 | Vector field (page number for startup, else 0) |
| failed_o | output | N_CPU | Bit n set: processor n timed out |
| done_o | output | 1 | Walk finished |

## Verification
The bench builds the block with four processors, two ticks per microsecond with a tick on every cycle, a 10 µs INIT delay, a 3 µs startup delay and a 20 µs timeout. With these values every per-target delay is a few tens of cycles, so all sixteen enable patterns can be swept. In each pattern, a chosen processor can be made to stay silent, which exercises the timeout path next to normal completions. Because every gap is short, the bench can check each command spacing to the exact cycle. This includes the busy-limited gap between the two INIT commands and the full timeout gap before the next target.

// File: rtl/ap_boot_pkg.sv
package ap_boot_pkg;

  typedef enum logic [1:0] {
    CMD_INIT_SET = 2'd0,
    CMD_INIT_CLR = 2'd1,
    CMD_STARTUP  = 2'd2
  } boot_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SELECT,
    S_POLL,
    S_WAIT,
    S_CHECK,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_IA,
    STEP_ID,
    STEP_SU1,
    STEP_SU2
  } boot_step_e;

  function automatic int id_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic boot_cmd_e step_cmd(input boot_step_e s);
    case (s)
      STEP_IA: return CMD_INIT_SET;
      STEP_ID: return CMD_INIT_CLR;
      default: return CMD_STARTUP;
    endcase
  endfunction

  // microseconds to wait after the command of step s
  function automatic int step_wait_us(input boot_step_e s, input int init_us, input int sipi_us);
    case (s)
      STEP_IA: return 0;
      STEP_ID: return init_us;
      default: return sipi_us;
    endcase
  endfunction

  function automatic logic step_has_page(input boot_step_e s);
    return (s == STEP_SU1) || (s == STEP_SU2);
  endfunction

endpackage

// File: rtl/ap_boot_timer.sv
module ap_boot_timer #(
  parameter int DLY_W = 20,
  parameter int TPU   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_us_i,
  input  logic             tick_i,
  output logic             expired_o
);
  localparam int TW = (TPU > 1) ? $clog2(TPU) : 1;

  logic [DLY_W-1:0] us_left;
  logic [TW-1:0]    sub_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      us_left <= '0;
      sub_cnt <= '0;
    end else if (load_i) begin
      us_left <= load_us_i;
      sub_cnt <= '0;
    end else if (tick_i && (us_left != '0)) begin
      if (sub_cnt == TW'(TPU - 1)) begin
        sub_cnt <= '0;
        us_left <= us_left - 1'b1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end
  end

  assign expired_o = (us_left == '0);

  // R6
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (load_us_i != '0)) |=> !expired_o);

  // R7
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(us_left));

endmodule

// File: rtl/ap_boot_pick.sv
module ap_boot_pick #(
  parameter int N_CPU = 4,
  parameter int IDX_W = 3
) (
  input  logic [N_CPU-1:0] mask_i,
  input  logic [IDX_W-1:0] base_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_CPU - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(base_i))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ap_boot_cmd.sv
module ap_boot_cmd #(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [1:0]      type_i,
  input  logic [ID_W-1:0] dest_i,
  input  logic [7:0]      vec_i,
  output logic            cmd_valid_o,
  output logic [1:0]      cmd_type_o,
  output logic [ID_W-1:0] cmd_dest_o,
  output logic [7:0]      cmd_vec_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid_o <= 1'b0;
      cmd_type_o  <= '0;
      cmd_dest_o  <= '0;
      cmd_vec_o   <= '0;
    end else begin
      cmd_valid_o <= issue_i;
      if (issue_i) begin
        cmd_type_o <= type_i;
        cmd_dest_o <= dest_i;
        cmd_vec_o  <= vec_i;
      end
    end
  end
endmodule

// File: rtl/ap_boot_seq.sv
module ap_boot_seq
  import ap_boot_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int DLY_W   = 20,
  parameter int TPU     = 100,
  parameter int INIT_US = 10000,
  parameter int SIPI_US = 200
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [N_CPU-1:0]            enabled_i,
  input  logic [7:0]                  page_i,
  input  logic                        busy_i,
  input  logic [N_CPU-1:0]            online_i,
  input  logic                        tick_i,
  input  logic [DLY_W-1:0]            timeout_us_i,
  output logic                        cmd_valid_o,
  output logic [1:0]                  cmd_type_o,
  output logic [id_bits(N_CPU)-1:0]   cmd_dest_o,
  output logic [7:0]                  cmd_vec_o,
  output logic [N_CPU-1:0]            failed_o,
  output logic                        done_o
);
  localparam int ID_W  = id_bits(N_CPU);
  localparam int IDX_W = $clog2(N_CPU + 1);

  seq_state_e       state;
  boot_step_e       step;
  logic [ID_W-1:0]  cur;
  logic [IDX_W-1:0] base;
  logic [N_CPU-1:0] failed_q;

  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             tmr_load, tmr_exp;
  logic [DLY_W-1:0] tmr_us;
  logic             issue_w;
  boot_cmd_e        issue_type;
  logic [7:0]       issue_vec;
  logic             target_ok_w, target_fail_w, wait_last_w, accept_start_w;

  ap_boot_pick #(.N_CPU(N_CPU), .IDX_W(IDX_W)) pick_i (
    .mask_i (enabled_i),
    .base_i (base),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  ap_boot_timer #(.DLY_W(DLY_W), .TPU(TPU)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .load_us_i(tmr_us),
    .tick_i   (tick_i),
    .expired_o(tmr_exp)
  );

  ap_boot_cmd #(.ID_W(ID_W)) cmd_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_w),
    .type_i     (issue_type),
    .dest_i     (cur),
    .vec_i      (issue_vec),
    .cmd_valid_o(cmd_valid_o),
    .cmd_type_o (cmd_type_o),
    .cmd_dest_o (cmd_dest_o),
    .cmd_vec_o  (cmd_vec_o)
  );

  // named internal events
  always_comb begin
    accept_start_w = start_i && ((state == S_IDLE) || (state == S_DONE));
    issue_w        = (state == S_POLL) && !busy_i;
    issue_type     = step_cmd(step);
    issue_vec      = step_has_page(step) ? page_i : 8'h00;
    wait_last_w    = (state == S_WAIT) && tmr_exp && (step == STEP_SU2);
    target_ok_w    = (state == S_CHECK) && online_i[cur];
    target_fail_w  = (state == S_CHECK) && !online_i[cur] && tmr_exp;
    tmr_load       = issue_w || wait_last_w;
    tmr_us         = issue_w ? DLY_W'(step_wait_us(step, INIT_US, SIPI_US)) : timeout_us_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step     <= STEP_IA;
      cur      <= '0;
      base     <= '0;
      failed_q <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (accept_start_w) begin
            base     <= '0;
            failed_q <= '0;
            state    <= S_SELECT;
          end
        end
        S_SELECT: begin
          if (pick_found) begin
            cur   <= pick_idx[ID_W-1:0];
            step  <= STEP_IA;
            state <= S_POLL;
          end else begin
            state <= S_DONE;
          end
        end
        S_POLL: begin
          if (issue_w) state <= S_WAIT;
        end
        S_WAIT: begin
          if (tmr_exp) begin
            case (step)
              STEP_IA:  begin step <= STEP_ID;  state <= S_POLL; end
              STEP_ID:  begin step <= STEP_SU1; state <= S_POLL; end
              STEP_SU1: begin step <= STEP_SU2; state <= S_POLL; end
              default:  state <= S_CHECK;
            endcase
          end
        end
        S_CHECK: begin
          if (target_ok_w || target_fail_w) begin
            base  <= IDX_W'(cur) + IDX_W'(1);
            state <= S_SELECT;
            if (target_fail_w) failed_q[cur] <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign failed_o = failed_q;
  assign done_o   = (state == S_DONE);

  // R5
  busy_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(!busy_i));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R2
  enabled_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> enabled_i[cmd_dest_o]);

  // R4
  page_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && (cmd_type_o == 2'd2)) |-> (cmd_vec_o == $past(page_i)));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R8
  no_cmd_in_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK) |=> !cmd_valid_o);

endmodule

// File: tb/ap_boot_seq_tb.sv
module ap_boot_seq_tb_top;
  localparam int N        = 4;
  localparam int DW       = 20;
  localparam int TPU      = 2;
  localparam int INIT_US  = 10;
  localparam int SIPI_US  = 3;
  localparam int TO_US    = 20;
  localparam int BUSY_LEN = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [N-1:0]  enabled_i = '0;
  logic [7:0]    page_i = '0;
  logic          busy_i = 1'b0;
  logic [N-1:0]  online_i = '0;
  logic          tick_i = 1'b1;
  logic [DW-1:0] timeout_us_i = DW'(TO_US);
  logic          cmd_valid_o;
  logic [1:0]    cmd_type_o;
  logic [1:0]    cmd_dest_o;
  logic [7:0]    cmd_vec_o;
  logic [N-1:0]  failed_o;
  logic          done_o;

  ap_boot_seq #(.N_CPU(N), .DLY_W(DW), .TPU(TPU), .INIT_US(INIT_US), .SIPI_US(SIPI_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .enabled_i(enabled_i), .page_i(page_i),
    .busy_i(busy_i), .online_i(online_i), .tick_i(tick_i), .timeout_us_i(timeout_us_i),
    .cmd_valid_o(cmd_valid_o), .cmd_type_o(cmd_type_o), .cmd_dest_o(cmd_dest_o),
    .cmd_vec_o(cmd_vec_o), .failed_o(failed_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit clr_req = 1'b0;
  int dead_cpu = -1;

  int ncmd;
  int ctype[32];
  int cdest[32];
  int cvec[32];
  int ccyc[32];
  int on_cyc[N];
  int su_seen[N];
  int resp_cnt[N];
  int busy_left = 0;
  int busy_viol = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor, busy model, processor model
  always @(negedge clk) begin
    cyc++;
    if (clr_req) begin
      ncmd = 0;
      online_i <= '0;
      for (int n = 0; n < N; n++) begin
        su_seen[n] = 0; resp_cnt[n] = -1; on_cyc[n] = -1;
      end
    end else begin
      if (cmd_valid_o) begin
        if (busy_i) busy_viol++;
        if (ncmd < 32) begin
          ctype[ncmd] = int'(cmd_type_o); cdest[ncmd] = int'(cmd_dest_o);
          cvec[ncmd] = int'(cmd_vec_o);  ccyc[ncmd] = cyc;
        end
        ncmd++;
        if (cmd_type_o == 2'd2) begin
          su_seen[cmd_dest_o]++;
          if (su_seen[cmd_dest_o] == 2 && int'(cmd_dest_o) != dead_cpu)
            resp_cnt[cmd_dest_o] = 2 + 8 * int'(cmd_dest_o);
        end
      end
      for (int n = 0; n < N; n++) begin
        if (resp_cnt[n] > 0) begin
          resp_cnt[n]--;
          if (resp_cnt[n] == 0) begin
            online_i[n] <= 1'b1; on_cyc[n] = cyc;
          end
        end
      end
    end
    if (cmd_valid_o) busy_left = BUSY_LEN;
    if (busy_left > 0) begin busy_i <= 1'b1; busy_left--; end
    else busy_i <= 1'b0;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_case(input int mask, input int dead);
    int exp_n;
    int slot;
    int prev;
    logic [N-1:0] exp_fail;
    @(negedge clk);
    clr_req = 1'b1;
    dead_cpu = dead;
    @(negedge clk);
    clr_req = 1'b0;
    enabled_i = N'(mask);
    page_i = 8'(8'h20 + mask);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 4000 && !done_o; k++) begin
      @(negedge clk);
      start_i = (k == 12);
    end
    start_i = 1'b0;
    chk(done_o, "R10", "done after walk", int'(done_o), 1);
    exp_n = 0; exp_fail = '0;
    for (int n = 0; n < N; n++) if (mask[n]) begin
      exp_n++;
      if (n == dead) exp_fail[n] = 1'b1;
    end
    chk(ncmd == 4 * exp_n, (mask == 0) ? "R11" : "R3", "command count", ncmd, 4 * exp_n);
    chk(failed_o == exp_fail, "R9", "failed map", int'(failed_o), int'(exp_fail));
    slot = 0; prev = -1;
    if (ncmd == 4 * exp_n) begin
      for (int n = 0; n < N; n++) if (mask[n]) begin
        for (int s = 0; s < 4; s++) begin
          chk(cdest[slot + s] == n, "R2", "destination", cdest[slot + s], n);
          chk(ctype[slot + s] == ((s < 2) ? s : 2), "R3", "command type", ctype[slot + s], (s < 2) ? s : 2);
          chk(cvec[slot + s] == ((s < 2) ? 0 : int'(page_i)), "R4", "vector", cvec[slot + s], (s < 2) ? 0 : int'(page_i));
        end
        chk(ccyc[slot + 1] - ccyc[slot] == BUSY_LEN + 1, "R5", "INIT pair gap", ccyc[slot + 1] - ccyc[slot], BUSY_LEN + 1);
        chk(ccyc[slot + 2] - ccyc[slot + 1] == INIT_US * TPU + 2, "R6", "INIT to startup gap",
            ccyc[slot + 2] - ccyc[slot + 1], INIT_US * TPU + 2);
        chk(ccyc[slot + 3] - ccyc[slot + 2] == SIPI_US * TPU + 2, "R7", "startup gap",
            ccyc[slot + 3] - ccyc[slot + 2], SIPI_US * TPU + 2);
        if (prev >= 0) begin
          if (prev == dead)
            chk(ccyc[slot] - ccyc[slot - 1] == (SIPI_US + TO_US) * TPU + 4, "R9", "timeout gap",
                ccyc[slot] - ccyc[slot - 1], (SIPI_US + TO_US) * TPU + 4);
          else
            chk(on_cyc[prev] >= 0 && ccyc[slot] > on_cyc[prev], "R8", "next after completion",
                ccyc[slot], on_cyc[prev] + 1);
        end
        prev = n;
        slot += 4;
      end
    end
    repeat (3) @(negedge clk);
    chk(done_o, "R10", "done held", int'(done_o), 1);
  endtask

  initial begin
    for (int n = 0; n < N; n++) begin su_seen[n] = 0; resp_cnt[n] = -1; on_cyc[n] = -1; end
    ncmd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!cmd_valid_o, "R1", "no command after reset", int'(cmd_valid_o), 0);
    chk(!done_o, "R1", "done low after reset", int'(done_o), 0);
    chk(failed_o == '0, "R1", "failed clear after reset", int'(failed_o), 0);
    for (int m = 0; m < 16; m++) begin
      run_case(m, (m % 5 == 4) ? -1 : (m % 5));
    end
    chk(busy_viol == 0, "R5", "writes while busy", busy_viol, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule